// File: doc/BRIEF.md
# Hotplug Slot Event Register

This block keeps the slot event state that an operating system reads while it services hot-add and hot-remove of PCI slots. Each slot has its own pending-removal bit. The bit is raised by an unplug request for that slot and is lowered only when that same slot is ejected. Because of this, overlapping requests never wipe one another out. A pending removal that the OS has not yet serviced survives any number of later events on other slots.

Plug events are not tracked one by one. The block reports a device-check set instead: every slot that is both present and hotpluggable. The OS may re-check those slots harmlessly, and the same set is offered on the legacy up-register read. A single notice flag records that a plug happened since the last status read. An interrupt request stays high while any removal is pending or the notice is set. A synchronous reset flushes all pending removals. It reports them once on the eject output as completed ejections.

Top module: `hpe_event_reg`

## Requirements
- R1: An unplug strobe with slot index k sets bit k of `rd_down` on the next clock edge, and that bit stays set through any later events until slot k is accepted by an eject write.
- R2: An eject write clears, on the next edge, exactly the bits of `rd_down` that are set in both `eject_mask` and `rd_down`; all other bits of `rd_down` keep their value, and `eject_done` shows the cleared set for one cycle after that edge.
- R3: Eject mask bits whose slot has no pending removal are ignored: they change neither `rd_down` nor `eject_done`.
- R4: When an unplug request and an accepted eject address the same slot in the same cycle, the slot is reported in `eject_done`, and its `rd_down` bit is still set afterwards, so the new request is not lost.
- R5: `rd_up` and `devcheck` both equal `present_mask & hotplug_mask`, combinationally, with no clock delay.
- R6: A plug strobe sets the plug notice on the next edge. A status read (`rd_stb`) clears it. When a plug and a read occur in the same cycle, the notice ends up set. `irq` is high exactly when `rd_down` is nonzero or the notice is set.
- R7: A plug strobe and an unplug strobe naming the same slot in the same cycle resolve to the unplug: the removal bit is set and the plug notice is not raised.
- R8: While `rst_n` is low at a clock edge, `rd_down` and the plug notice become zero, and `eject_done` takes the removal set that was pending before that edge. A second reset edge makes `eject_done` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| plug_stb | input | 1 | Slot hot-add event strobe |
| plug_slot | input | IDX_W | Slot index of the hot-add |
| unplug_stb | input | 1 | Slot removal request strobe |
| unplug_slot | input | IDX_W | Slot index of the removal request |
| eject_we | input | 1 | Eject write strobe from the OS |
| eject_mask | input | NUM_SLOTS | Slots the OS ejects |
| rd_stb | input | 1 | Status read; acknowledges the plug notice |
| present_mask | input | NUM_SLOTS | Slots currently occupied |
| hotplug_mask | input | NUM_SLOTS | Slots that support hotplug |
| rd_down | output | NUM_SLOTS | Pending-removal register read value |
| rd_up | output | NUM_SLOTS | Legacy up-register read value |
| devcheck | output | NUM_SLOTS | Slots the OS should device-check |
| eject_done | output | NUM_SLOTS | Slots ejected or flushed in the last cycle |
| irq | output | 1 | Event-pending interrupt request |

## Verification
The bench builds the block with NUM_SLOTS set to 8. At that width every slot can be unplugged and ejected singly, and in bulk with an all-ones mask. Both the lowest and highest slot indices are exercised on the eject path. Several removals are held pending together, so the check that one eject leaves the other pending slots untouched is meaningful. The same-cycle collisions of unplug with eject, of plug with unplug and of plug with read are each driven on purpose. The reset flush is checked with more than one removal pending.

// File: rtl/hpe_pkg.sv
// Package: shared helpers for the hotplug slot event register.
// Assumes slot indices wider than the slot count decode to no slot.
package hpe_pkg;

    // Turn a slot index into a one-hot slot vector (zero when out of range).
    function automatic logic [63:0] slot_onehot(input int unsigned idx, input int unsigned nslots);
        logic [63:0] v;
        v = '0;
        if (idx < nslots) begin
            v[idx] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/hpe_remove_tracker.sv
// Module: per-slot pending-removal bits with individual set and clear.
// Each slot sets on its own request and clears only on its own accepted
// eject; a same-cycle set beats the clear. Reset flushes every bit and
// reports the flushed set on eject_done.
module hpe_remove_tracker #(
    parameter int NUM_SLOTS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] set_vec,
    input  logic                 eject_we,
    input  logic [NUM_SLOTS-1:0] eject_mask,
    output logic [NUM_SLOTS-1:0] pend,
    output logic [NUM_SLOTS-1:0] eject_done
);

    logic [NUM_SLOTS-1:0] accept;

    // Ejects count only for slots that have a removal pending.
    always_comb begin
        accept = eject_we ? (eject_mask & pend) : '0;
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // One slot's removal bit: set wins over clear, reset flushes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[s] <= 1'b0;
            end else if (set_vec[s]) begin
                pend[s] <= 1'b1;
            end else if (accept[s]) begin
                pend[s] <= 1'b0;
            end
        end
    end

    // Report ejected slots; on reset the flushed pending set is reported.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eject_done <= pend;
        end else begin
            eject_done <= accept;
        end
    end

endmodule

// File: rtl/hpe_plug_notice.sv
// Module: single plug-notice flag, set by an accepted plug event and
// cleared by a status read; a plug in the same cycle as a read wins.
module hpe_plug_notice (
    input  logic clk,
    input  logic rst_n,
    input  logic plug_evt,
    input  logic rd_stb,
    output logic notice
);

    // Hold the notice until a read without a simultaneous plug.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notice <= 1'b0;
        end else if (plug_evt) begin
            notice <= 1'b1;
        end else if (rd_stb) begin
            notice <= 1'b0;
        end
    end

endmodule

// File: rtl/hpe_event_reg.sv
// Module: hotplug slot event register top. Decodes plug and unplug
// requests, tracks removals per slot, forms the device-check set and
// drives the interrupt request. Assumes at most one plug and one unplug
// request per cycle; NUM_SLOTS is at most 64.
module hpe_event_reg #(
    parameter int NUM_SLOTS = 32,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 plug_stb,
    input  logic [IDX_W-1:0]     plug_slot,
    input  logic                 unplug_stb,
    input  logic [IDX_W-1:0]     unplug_slot,
    input  logic                 eject_we,
    input  logic [NUM_SLOTS-1:0] eject_mask,
    input  logic                 rd_stb,
    input  logic [NUM_SLOTS-1:0] present_mask,
    input  logic [NUM_SLOTS-1:0] hotplug_mask,
    output logic [NUM_SLOTS-1:0] rd_down,
    output logic [NUM_SLOTS-1:0] rd_up,
    output logic [NUM_SLOTS-1:0] devcheck,
    output logic [NUM_SLOTS-1:0] eject_done,
    output logic                 irq
);
    import hpe_pkg::*;

    logic [63:0]          unplug_wide;
    logic [NUM_SLOTS-1:0] unplug_vec;
    logic                 same_slot;
    logic                 plug_evt;
    logic                 notice;

    // Decode the unplug index into a slot vector.
    always_comb begin
        unplug_wide = slot_onehot(int'(unplug_slot), NUM_SLOTS);
        unplug_vec  = unplug_stb ? unplug_wide[NUM_SLOTS-1:0] : '0;
    end

    // A plug colliding with an unplug of the same slot is dropped.
    always_comb begin
        same_slot = unplug_stb && (plug_slot == unplug_slot);
        plug_evt  = plug_stb && !same_slot;
    end

    hpe_remove_tracker #(.NUM_SLOTS(NUM_SLOTS)) u_remove (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (unplug_vec),
        .eject_we   (eject_we),
        .eject_mask (eject_mask),
        .pend       (rd_down),
        .eject_done (eject_done)
    );

    hpe_plug_notice u_notice (
        .clk      (clk),
        .rst_n    (rst_n),
        .plug_evt (plug_evt),
        .rd_stb   (rd_stb),
        .notice   (notice)
    );

    // Device-check set and legacy up value: present and hotpluggable slots.
    always_comb begin
        devcheck = present_mask & hotplug_mask;
        rd_up    = devcheck;
    end

    // Interrupt while any removal is pending or a plug is unread.
    always_comb begin
        irq = (|rd_down) || notice;
    end

endmodule

// File: rtl/hpe_event_reg_chk.sv
// Module: assertion checker for hpe_event_reg, attached by bind.
module hpe_event_reg_chk #(
    parameter int NUM_SLOTS = 32,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 plug_stb,
    input logic                 unplug_stb,
    input logic [IDX_W-1:0]     unplug_slot,
    input logic                 eject_we,
    input logic [NUM_SLOTS-1:0] eject_mask,
    input logic [NUM_SLOTS-1:0] present_mask,
    input logic [NUM_SLOTS-1:0] rd_down,
    input logic [NUM_SLOTS-1:0] rd_up,
    input logic [NUM_SLOTS-1:0] eject_done,
    input logic                 irq
);

    logic [NUM_SLOTS-1:0] req_vec;
    logic [NUM_SLOTS-1:0] ej_vec;
    logic                 seen_run;

    // Bench-independent copy of the request decode, for the properties.
    always_comb begin
        req_vec = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (unplug_stb && (int'(unplug_slot) == i)) req_vec[i] = 1'b1;
        end
        ej_vec = eject_we ? eject_mask : '0;
    end

    // Marks that one out-of-reset edge has passed, so $past is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_run <= 1'b0;
        else        seen_run <= 1'b1;
    end

    // R1
    new_bits_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_run |-> ((rd_down & ~$past(rd_down) & ~$past(req_vec)) == '0));

    // R2
    cleared_bits_from_eject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_run |-> (($past(rd_down) & ~rd_down & ~$past(ej_vec)) == '0));

    // R3
    eject_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_run |-> ((eject_done & ~$past(rd_down)) == '0));

    // R4
    request_survives_eject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_run |-> (($past(req_vec) & ~rd_down) == '0));

    // R5
    devcheck_within_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_up & ~present_mask) == '0);

    // R6
    irq_with_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_down) |-> irq);

    // R6
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_run && $rose(irq)) |-> $past(plug_stb || unplug_stb));

endmodule

bind hpe_event_reg hpe_event_reg_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .plug_stb     (plug_stb),
    .unplug_stb   (unplug_stb),
    .unplug_slot  (unplug_slot),
    .eject_we     (eject_we),
    .eject_mask   (eject_mask),
    .present_mask (present_mask),
    .rd_down      (rd_down),
    .rd_up        (rd_up),
    .eject_done   (eject_done),
    .irq          (irq)
);

// File: tb/hpe_event_reg_test.sv
// Bench: vector table walked by one loop, then directed tests.
module hpe_event_reg_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int IW = 3;

    typedef struct packed {
        logic          p;
        logic [IW-1:0] ps;
        logic          u;
        logic [IW-1:0] us;
        logic          e;
        logic [N-1:0]  em;
        logic          r;
        logic [N-1:0]  xd;
        logic [N-1:0]  xe;
        logic          xi;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        // p  ps     u   us     e   em      r   down    ej      irq
        '{1'b0,3'd0,1'b1,3'd2,1'b0,8'h00,1'b0,8'h04,8'h00,1'b1}, // R1 unplug 2
        '{1'b0,3'd0,1'b1,3'd5,1'b0,8'h00,1'b0,8'h24,8'h00,1'b1}, // R1 unplug 5
        '{1'b0,3'd0,1'b0,3'd0,1'b1,8'h04,1'b0,8'h20,8'h04,1'b1}, // R2 eject 2
        '{1'b0,3'd0,1'b0,3'd0,1'b1,8'h01,1'b0,8'h20,8'h00,1'b1}, // R3 ignored
        '{1'b0,3'd0,1'b1,3'd5,1'b1,8'h20,1'b0,8'h20,8'h20,1'b1}, // R4 collide
        '{1'b0,3'd0,1'b0,3'd0,1'b1,8'h20,1'b0,8'h00,8'h20,1'b0}, // R2 eject 5
        '{1'b1,3'd3,1'b0,3'd0,1'b0,8'h00,1'b0,8'h00,8'h00,1'b1}, // R6 plug
        '{1'b0,3'd0,1'b0,3'd0,1'b0,8'h00,1'b1,8'h00,8'h00,1'b0}, // R6 read
        '{1'b1,3'd1,1'b1,3'd1,1'b0,8'h00,1'b0,8'h02,8'h00,1'b1}, // R7 same slot
        '{1'b0,3'd0,1'b0,3'd0,1'b1,8'h02,1'b0,8'h00,8'h02,1'b0}, // R7 no notice
        '{1'b1,3'd4,1'b0,3'd0,1'b0,8'h00,1'b1,8'h00,8'h00,1'b1}, // R6 plug+read
        '{1'b0,3'd0,1'b0,3'd0,1'b0,8'h00,1'b1,8'h00,8'h00,1'b0}, // R6 read
        '{1'b0,3'd0,1'b1,3'd6,1'b0,8'h00,1'b0,8'h40,8'h00,1'b1}, // R1 unplug 6
        '{1'b0,3'd0,1'b1,3'd7,1'b0,8'h00,1'b0,8'hC0,8'h00,1'b1}, // R1 unplug 7
        '{1'b0,3'd0,1'b0,3'd0,1'b1,8'hFF,1'b0,8'h00,8'hC0,1'b0}  // R3 bulk
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          plug_stb = 1'b0;
    logic [IW-1:0] plug_slot = '0;
    logic          unplug_stb = 1'b0;
    logic [IW-1:0] unplug_slot = '0;
    logic          eject_we = 1'b0;
    logic [N-1:0]  eject_mask = '0;
    logic          rd_stb = 1'b0;
    logic [N-1:0]  present_mask = '0;
    logic [N-1:0]  hotplug_mask = '0;
    logic [N-1:0]  rd_down, rd_up, devcheck, eject_done;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpe_event_reg #(.NUM_SLOTS(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .plug_stb(plug_stb), .plug_slot(plug_slot),
        .unplug_stb(unplug_stb), .unplug_slot(unplug_slot),
        .eject_we(eject_we), .eject_mask(eject_mask), .rd_stb(rd_stb),
        .present_mask(present_mask), .hotplug_mask(hotplug_mask),
        .rd_down(rd_down), .rd_up(rd_up), .devcheck(devcheck),
        .eject_done(eject_done), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive inputs after a falling edge, sample one cycle later off-edge.
    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs;
        plug_stb = 1'b0; unplug_stb = 1'b0; eject_we = 1'b0; rd_stb = 1'b0;
        eject_mask = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8", "reset down", rd_down, 8'h00);
        check("R8", "reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        step();
        check("R8", "post-reset eject_done", eject_done, 8'h00);

        for (int i = 0; i < NV; i++) begin
            plug_stb = VEC[i].p;   plug_slot = VEC[i].ps;
            unplug_stb = VEC[i].u; unplug_slot = VEC[i].us;
            eject_we = VEC[i].e;   eject_mask = VEC[i].em;
            rd_stb = VEC[i].r;
            step();
            idle_inputs();
            check("R1/R2", $sformatf("vec %0d down", i), rd_down, VEC[i].xd);
            check("R2/R3", $sformatf("vec %0d eject_done", i), eject_done, VEC[i].xe);
            check("R6", $sformatf("vec %0d irq", i), {7'b0, irq}, {7'b0, VEC[i].xi});
        end

        // R5: device-check set follows the masks with no clock delay.
        present_mask = 8'hF3; hotplug_mask = 8'h5E;
        #1;
        check("R5", "devcheck", devcheck, 8'h52);
        check("R5", "rd_up", rd_up, 8'h52);
        present_mask = 8'hFF; hotplug_mask = 8'h81;
        #1;
        check("R5", "devcheck edge slots", devcheck, 8'h81);

        // R8: reset flushes pending removals and reports them once.
        unplug_stb = 1'b1; unplug_slot = 3'd0;
        step();
        unplug_slot = 3'd3;
        step();
        idle_inputs();
        check("R1", "two pending", rd_down, 8'h09);
        rst_n = 1'b0;
        step();
        check("R8", "flush down", rd_down, 8'h00);
        check("R8", "flush eject_done", eject_done, 8'h09);
        step();
        check("R8", "second reset edge eject_done", eject_done, 8'h00);
        rst_n = 1'b1;
        step();
        check("R8", "irq after flush", {7'b0, irq}, 8'h00);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule